// File: doc/BRIEF.md
# Segmented Associative Data Cache

This block is a small data cache between a 32-bit core load/store port and a word-wide memory port. Its storage is split into four equal segments. Two address bits choose the segment. Within a segment any line may hold any tag, so every segment is a fully associative set. A read that hits returns data combinationally in the cycle of the request. A read that misses allocates a line, writes back the old contents if they are dirty, and refills the line one word at a time. The read is then answered as a hit.

Writes never allocate. Each write request carries its own policy bit. A write-through write updates the line if present and always writes memory once. A write-back write that hits updates only the line and marks it dirty. The victim line for a refill comes from a free-running LFSR, and lines flagged as locked are skipped. A maintenance port locks and unlocks lines, invalidates the whole cache and cleans a single line. The core sees a stall through `req_ready` while memory traffic is in flight.

Top module: `seg_dcache`

## Requirements
- R1: A read that misses in a segment with an unlocked line performs exactly LINE_WORDS memory reads of the aligned line and then returns the memory word. Address fields are: byte offset addr[1:0], word in line addr[3:2], segment addr[5:4], tag addr[31:6] (default sizes). While `mem_req` is high and `mem_ack` is low, the memory request is held with address and direction stable.
- R2: A read hit raises `req_ready` in the same cycle as the request, with the cached word on `req_rdata` and no memory access.
- R3: A write that misses performs one memory write and allocates nothing, so a later read of that address misses.
- R4: A write-through write (`req_wthru`=1) that hits updates the line and performs one memory write. The memory holds the value when the write completes, and a later read hits with the new value.
- R5: A write-back write (`req_wthru`=0) that hits completes in its request cycle with no memory access. Memory keeps the old value and a later read returns the new one.
- R6: When the victim is valid and dirty, all LINE_WORDS words are written back to memory before any refill read. A clean or invalid victim causes no memory writes.
- R7: A line whose lock bit is set is never chosen as a victim, and it keeps hitting while other addresses miss. Lock is `mnt_op`=1 and unlock is `mnt_op`=2; both address line `mnt_idx` of segment `mnt_seg`.
- R8: When every line of the selected segment is locked, a read miss is served by exactly one memory read and nothing is allocated.
- R9: Invalidate-all (`mnt_op`=3) clears every valid and dirty bit without memory traffic, so previously cached addresses miss afterwards. Lock bits are kept.
- R10: Clean (`mnt_op`=4) writes a valid dirty line back to memory with LINE_WORDS writes and clears its dirty bit. A repeated clean, or a clean of a clean line, makes no memory access.
- R11: The maintenance port is accepted only when the controller is idle and no core request is present (`mnt_ready`), so a core request in the same cycle is served first.
- R12: The segments are independent: the same tag cached in two segments hits in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present, held until `req_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | DATA_W | Load data, valid with `req_ready` on loads |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mnt_valid | input | 1 | Maintenance operation present |
| mnt_op | input | 3 | 1 lock, 2 unlock, 3 invalidate-all, 4 clean line |
| mnt_seg | input | 2 | Segment addressed by lock, unlock and clean |
| mnt_idx | input | IDX_W | Line within the segment |
| mnt_ready | output | 1 | Maintenance operation accepted this cycle |

## Verification
The one case where two functions meet in a single cycle is a core load and a maintenance unlock presented together. The bench drives both on the same edge. It then checks three things: the core load is answered as a hit in that cycle, `mnt_ready` stays low, and the unlock is accepted only in the first cycle after the load is gone. Victim choice is random, so the bench locks all lines of a segment but one to pin the victim. The bench keeps a behavioural memory and an architectural copy of the last value written to each word. It compares every completed load against that copy in the cycle it completes. It counts memory reads and writes per access to judge allocation, write-back ordering and bypass.

// File: rtl/dcache_pkg.sv
// Shared types for the segmented data cache: controller states and
// maintenance operation codes. No logic.
package dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // serve hits, accept misses and maintenance
        ST_WB   = 3'd1,  // write a dirty line back word by word
        ST_FILL = 3'd2,  // refill a line word by word
        ST_WT   = 3'd3,  // single memory write (write-through or write miss)
        ST_BYP  = 3'd4   // single memory read, no allocation
    } state_e;

    typedef enum logic [2:0] {
        MNT_NONE   = 3'd0,
        MNT_LOCK   = 3'd1,
        MNT_UNLOCK = 3'd2,
        MNT_INVAL  = 3'd3,
        MNT_CLEAN  = 3'd4
    } mnt_e;

endpackage

// File: rtl/cache_lfsr.sv
// Free-running Fibonacci LFSR that steps on every clock.
// Assumes TAPS describes a maximal-length polynomial and SEED is non-zero.
module cache_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);

    logic fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(q & TAPS);

    // Shift on every clock, reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], fb};
    end

endmodule

// File: rtl/cache_tag_match.sv
// Parallel tag comparison across all lines of one segment.
// Assumes the controller never places one tag in two valid lines of a segment.
module cache_tag_match #(
    parameter int LINES = 4,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [LINES-1:0]            valid,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);

    logic [LINES-1:0] match;

    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == tag);
    end

    // Encode the matching line into an index.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cache_victim.sv
// Victim selection: start at a random index and take the first unlocked
// line scanning upward with wrap. Assumes LINES is a power of two.
module cache_victim #(
    parameter int LINES = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] lock,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] cand;

    // Circular scan for the first unlocked line from the start index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        for (int k = 0; k < LINES; k++) begin
            cand = start + IDX_W'(k);
            if (!found && !lock[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/seg_dcache.sv
// Segmented associative data cache. Four segments are selected by address
// bits above the line offset, and each segment is fully associative. Reads
// allocate on a miss, writes never allocate, and the policy is chosen per
// write. Assumes LINE_WORDS and SEG_LINES are powers of two (>= 2), the core
// holds its request until req_ready, and memory answers one request at a time.
module seg_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SEG_LINES  = 4,
    parameter int LFSR_W     = 8,
    localparam int IDX_W     = $clog2(SEG_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wthru,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mnt_valid,
    input  logic [2:0]        mnt_op,
    input  logic [1:0]        mnt_seg,
    input  logic [IDX_W-1:0]  mnt_idx,
    output logic              mnt_ready
);

    localparam int NSEG    = 4;
    localparam int SEG_W   = 2;
    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int SEG_LSB = BOFF_W + WOFF_W;
    localparam int TAG_LSB = SEG_LSB + SEG_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

    // Line storage and per-line state bits.
    logic [NSEG-1:0][SEG_LINES-1:0][TAG_W-1:0]                   tag_q;
    logic [NSEG-1:0][SEG_LINES-1:0][LINE_WORDS-1:0][DATA_W-1:0]  data_q;
    logic [NSEG-1:0][SEG_LINES-1:0]                              valid_q;
    logic [NSEG-1:0][SEG_LINES-1:0]                              dirty_q;
    logic [NSEG-1:0][SEG_LINES-1:0]                              lock_q;

    // Controller registers.
    state_e             state;
    logic [WOFF_W-1:0]  cnt;
    logic [SEG_W-1:0]   op_seg;
    logic [IDX_W-1:0]   op_idx;
    logic               wb_then_fill;
    logic [ADDR_W-1:0]  l_addr;
    logic [DATA_W-1:0]  l_wdata;

    // Request address fields.
    logic [SEG_W-1:0]   a_seg;
    logic [TAG_W-1:0]   a_tag;
    logic [WOFF_W-1:0]  a_word;
    logic [TAG_W-1:0]   l_tag;

    assign a_seg  = req_addr[TAG_LSB-1:SEG_LSB];
    assign a_tag  = req_addr[ADDR_W-1:TAG_LSB];
    assign a_word = req_addr[SEG_LSB-1:BOFF_W];
    assign l_tag  = l_addr[ADDR_W-1:TAG_LSB];

    // Per-segment lookup.
    logic [NSEG-1:0]            seg_hit;
    logic [NSEG-1:0][IDX_W-1:0] seg_hidx;
    logic                       hit;
    logic [IDX_W-1:0]           hidx;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        cache_tag_match #(.LINES(SEG_LINES), .TAG_W(TAG_W)) u_match (
            .tags  (tag_q[s]),
            .valid (valid_q[s]),
            .tag   (a_tag),
            .hit   (seg_hit[s]),
            .idx   (seg_hidx[s])
        );
    end

    assign hit  = seg_hit[a_seg];
    assign hidx = seg_hidx[a_seg];

    // Random start index and victim choice within the requested segment.
    logic [LFSR_W-1:0] lfsr_q;
    logic              vic_found;
    logic [IDX_W-1:0]  vic_idx;

    cache_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(8'hB8)), .SEED(LFSR_W'(8'h5A))) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (lfsr_q)
    );

    cache_victim #(.LINES(SEG_LINES)) u_victim (
        .lock  (lock_q[a_seg]),
        .start (lfsr_q[IDX_W-1:0]),
        .found (vic_found),
        .idx   (vic_idx)
    );

    // Core and memory port drive per state.
    always_comb begin
        req_ready = 1'b0;
        req_rdata = data_q[a_seg][hidx][a_word];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid && hit && (!req_write || !req_wthru)) req_ready = 1'b1;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[op_seg][op_idx], op_seg, cnt, {BOFF_W{1'b0}}};
                mem_wdata = data_q[op_seg][op_idx][cnt];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {l_tag, op_seg, cnt, {BOFF_W{1'b0}}};
            end
            ST_WT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {l_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
                mem_wdata = l_wdata;
                req_ready = mem_ack;
            end
            ST_BYP: begin
                mem_req   = 1'b1;
                mem_addr  = {l_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
                req_ready = mem_ack;
                req_rdata = mem_rdata;
            end
            default: ;
        endcase
    end

    assign mnt_ready = (state == ST_IDLE) && !req_valid;

    // Controller sequencing and line state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            op_seg       <= '0;
            op_idx       <= '0;
            wb_then_fill <= 1'b0;
            l_addr       <= '0;
            l_wdata      <= '0;
            valid_q      <= '0;
            dirty_q      <= '0;
            lock_q       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && !req_write) begin
                        if (!hit) begin
                            l_addr <= req_addr;
                            cnt    <= '0;
                            if (vic_found) begin
                                op_seg       <= a_seg;
                                op_idx       <= vic_idx;
                                wb_then_fill <= 1'b1;
                                if (valid_q[a_seg][vic_idx] && dirty_q[a_seg][vic_idx])
                                    state <= ST_WB;
                                else
                                    state <= ST_FILL;
                            end else begin
                                state <= ST_BYP;
                            end
                        end
                    end else if (req_valid) begin
                        if (hit) begin
                            data_q[a_seg][hidx][a_word] <= req_wdata;
                            if (!req_wthru) dirty_q[a_seg][hidx] <= 1'b1;
                        end
                        if (!hit || req_wthru) begin
                            l_addr  <= req_addr;
                            l_wdata <= req_wdata;
                            state   <= ST_WT;
                        end
                    end else if (mnt_valid) begin
                        case (mnt_op)
                            MNT_LOCK:   lock_q[mnt_seg][mnt_idx] <= 1'b1;
                            MNT_UNLOCK: lock_q[mnt_seg][mnt_idx] <= 1'b0;
                            MNT_INVAL: begin
                                valid_q <= '0;
                                dirty_q <= '0;
                            end
                            MNT_CLEAN: begin
                                if (valid_q[mnt_seg][mnt_idx] && dirty_q[mnt_seg][mnt_idx]) begin
                                    op_seg       <= mnt_seg;
                                    op_idx       <= mnt_idx;
                                    cnt          <= '0;
                                    wb_then_fill <= 1'b0;
                                    state        <= ST_WB;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_WORD) begin
                            dirty_q[op_seg][op_idx] <= 1'b0;
                            state <= wb_then_fill ? ST_FILL : ST_IDLE;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        data_q[op_seg][op_idx][cnt] <= mem_rdata;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_WORD) begin
                            tag_q[op_seg][op_idx]   <= l_tag;
                            valid_q[op_seg][op_idx] <= 1'b1;
                            dirty_q[op_seg][op_idx] <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WT, ST_BYP: begin
                    if (mem_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !(valid_q[op_seg][op_idx] && dirty_q[op_seg][op_idx]));

    // R7
    alloc_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !lock_q[op_seg][op_idx]);

    // R3
    wt_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WT) |=> $stable(valid_q));

    // R8
    byp_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYP) |=> $stable(valid_q));

endmodule

// File: tb/seg_dcache_tb.sv
// Bench for seg_dcache: a behavioural memory with varying latency, an
// architectural copy of every word, and a per-clock load comparison.
module seg_dcache_tb;

    localparam int IDX_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready;
    logic [31:0] req_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mnt_valid = 1'b0;
    logic [2:0]  mnt_op = '0;
    logic [1:0]  mnt_seg = '0;
    logic [IDX_W-1:0] mnt_idx = '0;
    logic        mnt_ready;

    always #10 clk = ~clk;

    seg_dcache u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wthru(req_wthru),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mnt_valid(mnt_valid), .mnt_op(mnt_op), .mnt_seg(mnt_seg), .mnt_idx(mnt_idx),
        .mnt_ready(mnt_ready)
    );

    logic [31:0] bmem [0:255];
    logic [31:0] aref [0:255];
    int checks = 0, errors = 0;
    int n_rd = 0, n_wr = 0, rd_at_wr = 0;
    int lat_cnt = 0;
    bit lat_sel = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 32'hA500_0000 + i * 32'h0001_0101;
            aref[i] = 32'hA500_0000 + i * 32'h0001_0101;
        end
    end

    // Memory model: one request at a time, latency alternating 0 and 2.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= bmem[mem_addr[9:2]];
                if (mem_we) begin
                    bmem[mem_addr[9:2]] <= mem_wdata;
                    n_wr     <= n_wr + 1;
                    rd_at_wr <= n_rd;
                end else begin
                    n_rd <= n_rd + 1;
                end
                lat_sel <= ~lat_sel;
                lat_cnt <= lat_sel ? 2 : 0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every completed load is compared against the architectural copy.
    always @(negedge clk) begin
        #2;
        if (rst_n && req_valid && req_ready && !req_write)
            chk(req_rdata == aref[req_addr[9:2]], "R1 load data", req_rdata, aref[req_addr[9:2]]);
    end

    function automatic logic [31:0] mk(input int t, input int s, input int w);
        return {22'b0, 4'(t), 2'(s), 2'(w), 2'b00};
    endfunction

    int waits, d_rd, d_wr, r0, w0;
    logic [31:0] rdv;

    task automatic access(input bit wr, input bit wt, input logic [31:0] a, input logic [31:0] wd);
        r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wthru = wt; req_addr = a; req_wdata = wd;
        waits = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rdv = req_rdata;
        @(posedge clk); #1;
        if (wr) aref[a[9:2]] = wd;
        req_valid = 1'b0;
        d_rd = n_rd - r0; d_wr = n_wr - w0;
    endtask

    task automatic mnt(input logic [2:0] op, input int s, input int idx);
        r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        mnt_valid = 1'b1; mnt_op = op; mnt_seg = 2'(s); mnt_idx = IDX_W'(idx);
        #1;
        while (!mnt_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        mnt_valid = 1'b0;
        @(negedge clk);
        while (!mnt_ready) @(negedge clk);
        d_rd = n_rd - r0; d_wr = n_wr - w0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mnt_ready == 1'b1, "R11 reset mnt_ready", 32'(mnt_ready), 32'd1);
        chk(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 32'd0);

        // R1 cold read miss: full line refill.
        access(0, 0, mk(1, 0, 2), 0);
        chk(d_rd == 4 && d_wr == 0, "R1 refill reads", 32'(d_rd), 32'd4);
        chk(rdv == aref[mk(1, 0, 2) >> 2], "R1 miss data", rdv, aref[mk(1, 0, 2) >> 2]);

        // R2 read hit in the same line.
        access(0, 0, mk(1, 0, 3), 0);
        chk(waits == 0, "R2 hit zero wait", 32'(waits), 32'd0);
        chk(d_rd == 0 && d_wr == 0, "R2 hit no traffic", 32'(d_rd + d_wr), 32'd0);

        // R12 same tag in another segment; both stay resident.
        access(0, 0, mk(1, 1, 0), 0);
        chk(d_rd == 4, "R12 second segment refill", 32'(d_rd), 32'd4);
        access(0, 0, mk(1, 0, 0), 0);
        chk(waits == 0 && d_rd == 0, "R12 segment 0 still hits", 32'(waits), 32'd0);
        access(0, 0, mk(1, 1, 1), 0);
        chk(waits == 0 && d_rd == 0, "R12 segment 1 hits", 32'(waits), 32'd0);

        // R3 write miss: one memory write, no allocation.
        access(1, 0, mk(5, 2, 1), 32'h1111_0001);
        chk(d_wr == 1 && d_rd == 0, "R3 write miss traffic", 32'(d_wr), 32'd1);
        chk(bmem[mk(5, 2, 1) >> 2] == 32'h1111_0001, "R3 memory updated", bmem[mk(5, 2, 1) >> 2], 32'h1111_0001);
        access(0, 0, mk(5, 2, 1), 0);
        chk(d_rd == 4, "R3 no allocation", 32'(d_rd), 32'd4);

        // R4 write-through hit.
        access(1, 1, mk(5, 2, 2), 32'h2222_0002);
        chk(d_wr == 1, "R4 write-through one write", 32'(d_wr), 32'd1);
        chk(bmem[mk(5, 2, 2) >> 2] == 32'h2222_0002, "R4 memory holds value", bmem[mk(5, 2, 2) >> 2], 32'h2222_0002);
        access(0, 0, mk(5, 2, 2), 0);
        chk(waits == 0 && d_rd == 0, "R4 cache updated", 32'(waits), 32'd0);

        // R5 write-back hit.
        access(1, 0, mk(1, 0, 1), 32'h5555_0005);
        chk(waits == 0 && d_rd == 0 && d_wr == 0, "R5 write-back silent", 32'(waits + d_rd + d_wr), 32'd0);
        chk(bmem[mk(1, 0, 1) >> 2] != 32'h5555_0005, "R5 memory untouched", bmem[mk(1, 0, 1) >> 2], 32'hA500_0000);
        access(0, 0, mk(1, 0, 1), 0);
        chk(waits == 0 && rdv == 32'h5555_0005, "R5 read new value", rdv, 32'h5555_0005);

        // R7 pin the victim to line 0 of segment 3.
        mnt(3'd1, 3, 1); mnt(3'd1, 3, 2); mnt(3'd1, 3, 3);
        access(0, 0, mk(2, 3, 0), 0);
        chk(d_rd == 4 && d_wr == 0, "R6 clean victim no writes", 32'(d_wr), 32'd0);
        access(1, 0, mk(2, 3, 1), 32'h6666_0006);
        access(0, 0, mk(3, 3, 0), 0);
        chk(d_wr == 4 && d_rd == 4, "R6 dirty victim written back", 32'(d_wr), 32'd4);
        chk(rd_at_wr == r0, "R6 write-back before refill", 32'(rd_at_wr), 32'(r0));
        chk(bmem[mk(2, 3, 1) >> 2] == 32'h6666_0006, "R6 dirty word in memory", bmem[mk(2, 3, 1) >> 2], 32'h6666_0006);
        access(0, 0, mk(2, 3, 0), 0);
        chk(d_rd == 4 && d_wr == 0, "R7 only unlocked line replaced", 32'(d_rd), 32'd4);

        // R10 clean a dirty line, then clean it again.
        access(1, 0, mk(2, 3, 2), 32'hAAAA_000A);
        mnt(3'd4, 3, 0);
        chk(d_wr == 4, "R10 clean writes line", 32'(d_wr), 32'd4);
        chk(bmem[mk(2, 3, 2) >> 2] == 32'hAAAA_000A, "R10 memory holds value", bmem[mk(2, 3, 2) >> 2], 32'hAAAA_000A);
        mnt(3'd4, 3, 0);
        chk(d_wr == 0 && d_rd == 0, "R10 repeated clean silent", 32'(d_wr), 32'd0);

        // R8 all lines of segment 3 locked.
        mnt(3'd1, 3, 0);
        access(0, 0, mk(4, 3, 0), 0);
        chk(d_rd == 1 && d_wr == 0, "R8 bypass read", 32'(d_rd), 32'd1);
        access(0, 0, mk(4, 3, 0), 0);
        chk(d_rd == 1, "R8 no allocation", 32'(d_rd), 32'd1);
        access(0, 0, mk(2, 3, 1), 0);
        chk(waits == 0 && d_rd == 0, "R7 locked line keeps hitting", 32'(waits), 32'd0);

        // R11 core load and unlock presented in the same cycle.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk(2, 3, 1);
        mnt_valid = 1'b1; mnt_op = 3'd2; mnt_seg = 2'd3; mnt_idx = '0;
        #1;
        chk(req_ready == 1'b1, "R11 core served first", 32'(req_ready), 32'd1);
        chk(mnt_ready == 1'b0, "R11 maintenance held off", 32'(mnt_ready), 32'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(mnt_ready == 1'b1, "R11 maintenance accepted after", 32'(mnt_ready), 32'd1);
        @(posedge clk); #1;
        mnt_valid = 1'b0;

        // R9 clean segment 0, then invalidate everything.
        for (int i = 0; i < 4; i++) mnt(3'd4, 0, i);
        chk(bmem[mk(1, 0, 1) >> 2] == 32'h5555_0005, "R10 segment 0 cleaned", bmem[mk(1, 0, 1) >> 2], 32'h5555_0005);
        mnt(3'd3, 0, 0);
        chk(d_rd == 0 && d_wr == 0, "R9 invalidate silent", 32'(d_rd + d_wr), 32'd0);
        access(0, 0, mk(1, 0, 1), 0);
        chk(d_rd == 4, "R9 previously cached misses", 32'(d_rd), 32'd4);
        access(0, 0, mk(5, 2, 2), 0);
        chk(d_rd == 4, "R9 segment 2 misses", 32'(d_rd), 32'd4);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule